// File: doc/BRIEF.md
# MDIO Management Master

This block runs single read or write transactions to an external PHY over the two-wire management bus: a clock (MDC) that the block makes by dividing the system clock, and a bidirectional data line that is brought out as separate output, output-enable and input pins. Software configures it through two 32-bit registers on a simple write port. The command register selects the PHY, the register inside it, the MDC rate, the direction, and a busy flag. The data register holds the 16-bit word to send, or the word that came back.

Software starts a transaction by writing the command register with the busy flag set. While busy is high, the block sends a 64-bit frame MSB first: 32 ones, start bits `01`, opcode (`01` write, `10` read), the 5-bit PHY address, the 5-bit register index, two turnaround bits and 16 data bits. On a read the block lets go of the data line from the first turnaround bit to the end of the frame, and it shifts the returned bits into the data register on rising MDC edges. The controller clears busy on the last falling MDC edge. Writes to either register are dropped while busy is high. As a result, the command and the outgoing word stay fixed for the whole frame.

Top module: `mdio_master`

## Requirements
- R1: The command register reads back as PHY address in bits 15:11, register index in bits 10:6, rate code in bits 4:2, direction in bit 1 (1 = write) and busy in bit 0. Bit 5 and bits 31:16 read as zero. A write with bit 0 clear updates the fields and starts nothing.
- R2: The data register holds bits 15:0 of the last accepted write, and its bits 31:16 read as zero.
- R3: Writing the command register with bit 0 set while idle sets busy on that clock edge. Busy clears exactly 64 MDC periods (64 × divisor system clocks) later.
- R4: The MDC period in system clocks is 42, 62, 16, 26 or 102 for rate codes 0, 1, 2, 3 and 4. MDC is low for the first half of each period and high for the second.
- R5: Rate codes 5, 6 and 7 give the period of code 4 (102 clocks).
- R6: MDC is low whenever busy is clear. The divider restarts at each start, so the first rising MDC edge comes half a period after busy rises.
- R7: The data line carries the frame MSB first, one bit per MDC period: 32 ones, `01`, the opcode, the PHY address, the register index, the turnaround (`10` on a write), then the data word.
- R8: While it drives the line, the block changes the data line only on falling MDC edges.
- R9: On a read the output enable is low from frame bit 46 to the end of the frame. The line is sampled on the 16 rising MDC edges of bits 48 to 63, and the word is in the data register when busy clears.
- R10: While busy is set, writes to the command and data registers have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 command, 1 data |
| cfg_wdata | input | 32 | Register write value |
| ctrl_rdata | output | 32 | Command register contents |
| data_rdata | output | 32 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |

## Verification
The assertions assume that software keeps the rules on register access: while busy is set, the stored command and outgoing word stay constant. Any write in that time is a protocol violation, which the block must drop. They also assume the responder changes the line only around falling MDC edges. The stimulus makes every register write one clock long and drives it away from the clock edge. It deliberately writes both registers in the middle of a transaction to confirm that these writes are dropped. The responder presents each read bit from the frame position the bench computes, so the value is stable across every rising MDC edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int BIT_W      = $clog2(FRAME_BITS);
  localparam int WORD_W     = 16;
  localparam int HALF_W     = 6;
  localparam int TA_FIRST   = FRAME_BITS - WORD_W - 2;
  localparam int DATA_FIRST = FRAME_BITS - WORD_W;
  localparam int PRE_BITS   = 32;

  typedef struct packed {
    logic [4:0] phy;
    logic [4:0] regidx;
    logic [2:0] rate;
    logic       wr;
  } mdio_cmd_t;

  // Half of the MDC period in system clocks; reserved codes use the slowest rate.
  function automatic logic [HALF_W-1:0] half_period(input logic [2:0] code);
    case (code)
      3'd0:    half_period = HALF_W'(21);
      3'd1:    half_period = HALF_W'(31);
      3'd2:    half_period = HALF_W'(8);
      3'd3:    half_period = HALF_W'(13);
      default: half_period = HALF_W'(51);
    endcase
  endfunction
endpackage

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              done,
  input  logic              rd_shift,
  input  logic              rd_bit,
  output mdio_cmd_t         cmd,
  output logic              busy,
  output logic              start,
  output logic [WORD_W-1:0] data_q
);
  mdio_cmd_t         cmd_d;
  logic              busy_d;
  logic [WORD_W-1:0] data_d;
  logic              wr_ok;

  assign wr_ok = cfg_we && !busy;
  assign start = wr_ok && !cfg_sel && cfg_wdata[0];

  always_comb begin
    cmd_d  = cmd;
    busy_d = busy;
    data_d = data_q;
    if (wr_ok) begin
      if (!cfg_sel) begin
        cmd_d.phy    = cfg_wdata[15:11];
        cmd_d.regidx = cfg_wdata[10:6];
        cmd_d.rate   = cfg_wdata[4:2];
        cmd_d.wr     = cfg_wdata[1];
        busy_d       = cfg_wdata[0];
      end else begin
        data_d = cfg_wdata[WORD_W-1:0];
      end
    end
    if (rd_shift) data_d = {data_q[WORD_W-2:0], rd_bit};
    if (done)     busy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd    <= '0;
      busy   <= 1'b0;
      data_q <= '0;
    end else begin
      cmd    <= cmd_d;
      busy   <= busy_d;
      data_q <= data_d;
    end
  end
endmodule

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              start,
  input  logic [HALF_W-1:0] half,
  output logic              mdc,
  output logic              rise,
  output logic              fall
);
  logic [HALF_W-1:0] cnt, cnt_d;
  logic              mdc_d;
  logic              term;

  assign term = run && (cnt == half - HALF_W'(1));
  assign rise = term && !mdc;
  assign fall = term && mdc;

  always_comb begin
    cnt_d = cnt;
    mdc_d = mdc;
    if (start || !run) begin
      cnt_d = '0;
      mdc_d = 1'b0;
    end else if (term) begin
      cnt_d = '0;
      mdc_d = !mdc;
    end else begin
      cnt_d = cnt + HALF_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else begin
      cnt <= cnt_d;
      mdc <= mdc_d;
    end
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  input  logic                  busy,
  input  logic                  is_read,
  input  logic                  rise,
  input  logic                  fall,
  output logic                  mdio_o,
  output logic                  mdio_oe,
  output logic                  done,
  output logic                  sample
);
  logic [FRAME_BITS-1:0] sh, sh_d;
  logic [BIT_W-1:0]      bitcnt, bitcnt_d;
  logic                  released;

  assign released = is_read && (bitcnt >= BIT_W'(TA_FIRST));
  assign done     = fall && (bitcnt == BIT_W'(FRAME_BITS - 1));
  assign sample   = rise && is_read && (bitcnt >= BIT_W'(DATA_FIRST));
  assign mdio_o   = busy ? sh[FRAME_BITS-1] : 1'b1;
  assign mdio_oe  = busy && !released;

  always_comb begin
    sh_d     = sh;
    bitcnt_d = bitcnt;
    if (start) begin
      sh_d     = frame;
      bitcnt_d = '0;
    end else if (fall) begin
      sh_d     = {sh[FRAME_BITS-2:0], 1'b1};
      bitcnt_d = bitcnt + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh     <= '0;
      bitcnt <= '0;
    end else begin
      sh     <= sh_d;
      bitcnt <= bitcnt_d;
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] ctrl_rdata,
  output logic [31:0] data_rdata,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  logic                  rst_meta, rst_sync_n;
  mdio_cmd_t             cmd;
  logic                  busy, start, done, sample, rise, fall;
  logic [WORD_W-1:0]     data_q;
  logic [FRAME_BITS-1:0] frame;
  logic                  go_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  assign go_wr = cfg_wdata[1];
  assign frame = {{PRE_BITS{1'b1}}, 2'b01,
                  go_wr ? 2'b01 : 2'b10,
                  cfg_wdata[15:11], cfg_wdata[10:6],
                  go_wr ? 2'b10 : 2'b11,
                  data_q};

  mdio_regs u_regs (
    .clk(clk), .rst_n(rst_sync_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .done(done), .rd_shift(sample), .rd_bit(mdio_i),
    .cmd(cmd), .busy(busy), .start(start), .data_q(data_q)
  );

  mdio_clkgen u_clk (
    .clk(clk), .rst_n(rst_sync_n), .run(busy), .start(start),
    .half(half_period(cmd.rate)), .mdc(mdc), .rise(rise), .fall(fall)
  );

  mdio_shifter u_shf (
    .clk(clk), .rst_n(rst_sync_n), .start(start), .frame(frame), .busy(busy),
    .is_read(!cmd.wr), .rise(rise), .fall(fall), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .done(done), .sample(sample)
  );

  assign ctrl_rdata = {16'h0000, cmd.phy, cmd.regidx, 1'b0, cmd.rate, cmd.wr, busy};
  assign data_rdata = {16'h0000, data_q};
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] ctrl_rdata,
  input logic [31:0] data_rdata,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  logic busy;
  assign busy = ctrl_rdata[0];

  // R1 / R2: reserved bits read as zero
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_rdata[31:16] == 16'h0) && !ctrl_rdata[5] && (data_rdata[31:16] == 16'h0));

  // R6: clock parked low when idle
  a_r6_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);

  // R3: busy ends together with a falling MDC edge
  a_r3_end_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));

  // R8: driven data moves only when MDC falls
  a_r8_change_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe && $past(mdio_oe) && !$fell(mdc)) |-> $stable(mdio_o));

  // R10: command fields frozen during a transaction
  a_r10_cmd_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ctrl_rdata[15:1]));

  // R10: outgoing word frozen during a write transaction
  a_r10_wdata_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && ctrl_rdata[1]) |-> $stable(data_rdata));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] ctrl_rdata, data_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // behavioural model state
  bit          m_busy = 0;
  int          t = 0;
  int          h = 51;
  int          m_bit = 0;
  logic [4:0]  m_phy = '0, m_reg = '0;
  logic [2:0]  m_cr = '0;
  bit          m_wr = 0;
  logic [15:0] m_data = '0;
  logic [63:0] m_frame = '0;
  logic [15:0] rd_word = 16'h0;
  bit          p_we = 0, p_sel = 0;
  logic [31:0] p_wd = '0;
  bit          prev_mdc = 0, prev_oe = 0, prev_o = 0;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;

  // simple PHY responder: presents read data during the data phase
  assign mdio_i = (m_busy && !m_wr && m_bit >= 48 && m_bit < 64) ? rd_word[63 - m_bit] : 1'b1;

  function automatic int half_of(input logic [2:0] c);
    case (c)
      3'd0: return 21;
      3'd1: return 31;
      3'd2: return 8;
      3'd3: return 13;
      default: return 51;
    endcase
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [4:0] phy, input logic [4:0] rg,
                                            input logic [2:0] cr, input bit wr, input bit go);
    return {16'h0, phy, rg, 1'b0, cr, wr, go};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // model advances by the edge just passed, then compares
  always @(negedge clk) begin
    if (m_busy) begin
      t++;
      if (t == 128 * h) begin
        m_busy = 0;
        if (!m_wr) m_data = rd_word;
      end
    end else if (p_we && rst_n) begin
      if (!p_sel) begin
        m_phy = p_wd[15:11]; m_reg = p_wd[10:6]; m_cr = p_wd[4:2]; m_wr = p_wd[1];
        if (p_wd[0]) begin
          m_busy  = 1; t = 0; h = half_of(m_cr);
          m_frame = {32'hFFFF_FFFF, 2'b01, m_wr ? 2'b01 : 2'b10, m_phy, m_reg, 2'b10, m_data};
        end
      end else begin
        m_data = p_wd[15:0];
      end
    end
    m_bit = m_busy ? t / (2 * h) : 0;

    chk("R1 command readback", ctrl_rdata, ctrl_word(m_phy, m_reg, m_cr, m_wr, m_busy));
    chk("R4/R6 mdc level", {31'h0, mdc}, {31'h0, m_busy ? (((t / h) % 2) == 1) : 1'b0});
    if (m_busy) begin
      chk("R9 output enable", {31'h0, mdio_oe}, {31'h0, !(!m_wr && m_bit >= 46)});
      if (m_wr || m_bit < 46)
        chk("R7 frame bit", {31'h0, mdio_o}, {31'h0, m_frame[63 - m_bit]});
      if (mdio_oe && prev_oe && mdc && prev_mdc)
        chk("R8 stable while mdc high", {31'h0, mdio_o}, {31'h0, prev_o});
    end else begin
      chk("R6 idle release", {31'h0, mdio_oe}, 32'h0);
      chk("R2 data readback", data_rdata, {16'h0, m_data});
    end
    prev_mdc = mdc; prev_oe = mdio_oe; prev_o = mdio_o;
    p_we = cfg_we; p_sel = cfg_sel; p_wd = cfg_wdata;
  end

  task automatic wr_reg(input bit sel, input logic [31:0] wd);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = wd;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_wdata = '0;
  endtask

  task automatic run_txn(input logic [4:0] phy, input logic [4:0] rg, input logic [2:0] cr,
                         input bit wr, input int period, input string tag, input bit poke);
    int c0, c1;
    logic [31:0] snap_c, snap_d;
    wr_reg(1'b0, ctrl_word(phy, rg, cr, wr, 1'b1));
    @(negedge clk);
    c0 = cyc;
    chk("R3 busy set at start", {31'h0, ctrl_rdata[0]}, 32'h1);
    if (poke) begin
      repeat (50) @(negedge clk);
      snap_c = ctrl_rdata; snap_d = data_rdata;
      wr_reg(1'b0, ctrl_word(~phy, ~rg, 3'd2, !wr, 1'b0));
      wr_reg(1'b1, 32'h0000_1234);
      @(negedge clk);
      chk("R10 command write ignored", ctrl_rdata, snap_c);
      if (wr) chk("R10 data write ignored", data_rdata, snap_d);
    end
    while (ctrl_rdata[0]) @(negedge clk);
    c1 = cyc;
    chk(tag, c1 - c0, 64 * period);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog expired: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R6 reset state ctrl", ctrl_rdata, 32'h0);
    chk("R2 reset state data", data_rdata, 32'h0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R2: upper write bits dropped
    wr_reg(1'b1, 32'hFFFF_A5C3);
    @(negedge clk);
    chk("R2 data upper zero", data_rdata, 32'h0000_A5C3);

    // R1: configuration without start; reserved bits forced to zero
    wr_reg(1'b0, 32'hABCD_0020 | ctrl_word(5'd3, 5'd4, 3'd1, 1'b1, 1'b0));
    @(negedge clk);
    chk("R1 fields no start", ctrl_rdata, ctrl_word(5'd3, 5'd4, 3'd1, 1'b1, 1'b0));

    // R3/R7/R10: write frame at /16 with ignored writes in flight
    run_txn(5'h11, 5'h0A, 3'd2, 1'b1, 16, "R3 write duration code 2", 1'b1);
    @(negedge clk);
    chk("R10 data kept after write", data_rdata, 32'h0000_A5C3);

    // R9: read frame at /26
    rd_word = 16'h3C5A;
    run_txn(5'h1F, 5'h1F, 3'd3, 1'b0, 26, "R3 read duration code 3", 1'b1);
    @(negedge clk);
    chk("R9 read word captured", data_rdata, 32'h0000_3C5A);

    rd_word = 16'h8001;
    run_txn(5'h00, 5'h01, 3'd2, 1'b0, 16, "R3 read duration code 2", 1'b0);
    @(negedge clk);
    chk("R9 read edge bits", data_rdata, 32'h0000_8001);

    // R4: remaining table entries
    wr_reg(1'b1, 32'h0000_5AA5);
    run_txn(5'h01, 5'h02, 3'd0, 1'b1, 42, "R4 period code 0", 1'b0);
    run_txn(5'h02, 5'h03, 3'd1, 1'b1, 62, "R4 period code 1", 1'b0);
    run_txn(5'h04, 5'h05, 3'd4, 1'b1, 102, "R4 period code 4", 1'b0);

    // R5: reserved codes fall back to the slowest rate
    rd_word = 16'hF00F;
    run_txn(5'h0C, 5'h0D, 3'd5, 1'b0, 102, "R5 reserved code 5", 1'b0);
    run_txn(5'h0E, 5'h10, 3'd7, 1'b1, 102, "R5 reserved code 7", 1'b0);

    repeat (5) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule